// File: doc/BRIEF.md
# Byte-wide SPI master with read-started transfers

This block is a simple SPI master that moves one byte per transfer. A host reaches it through three byte-wide registers at consecutive addresses: a data register, a control register and a status register. The control register picks which of three attached devices is selected, or none. It also picks a slow or a fast serial clock and decides what starts a transfer.

In write-start mode, a transfer begins when the host writes a byte to the data register, and that byte is shifted out. In read-start mode, a transfer begins when the host reads the data register. The read returns the byte received by the previous transfer, and the new transfer sends 0xFF. A host can therefore stream data in from a device with nothing but consecutive reads. The status register shows whether a transfer is running and reports the card-absent and card-write-protect inputs.

The serial side uses SPI mode 0 only: SCK idles low, data are sampled on the rising edge and changed on the falling edge, and the most significant bit goes first.

Top module: `spi_byte_master`

## Requirements
- R1: Register addresses are 0 = data, 1 = control and 2 = status. Address 3 reads 0x00. Control reads back bits 6, 4, 2 and 1 as written and reads its other bits as 0. After reset, control reads 0x02, data reads 0x00 and status reads only the two card inputs.
- R2: With control bit 6 = 0, a write to the data register while idle starts a transfer that shifts the written byte out on MOSI, most significant bit first. With control bit 6 = 0, a read of the data register starts nothing.
- R3: With control bit 6 = 1, a read of the data register while idle returns the byte received last and starts a transfer that sends 0xFF. With control bit 6 = 1, a write to the data register has no effect.
- R4: The byte received on MISO is readable in the data register from the cycle in which busy falls, and the data register changes at no other time.
- R5: Status bit 0 is high for exactly 16*SLOW_HALF clock cycles per transfer when control bit 2 was 0 at the start of the transfer, and for exactly 16*FAST_HALF clock cycles when it was 1. A later change of control bit 2 does not affect a transfer already running.
- R6: The select code {control bit 4, control bit 1} drives the active-low chip selects cs_n_o[0] (card) for code 00, cs_n_o[1] (flash) for code 10 and cs_n_o[2] (clock chip) for code 11. Code 01 selects none of them. At most one chip select is low at any time.
- R7: Status bit 3 equals card_absent_i and status bit 4 equals card_wp_i. Status bits 7..5, 2 and 1 read 0.
- R8: A trigger that arrives while busy is ignored. The running transfer keeps its byte and its length, and no second transfer follows.
- R9: SCK is low whenever the block is idle. During a transfer, MOSI changes only on a falling SCK edge, and MISO is sampled on the rising SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe, one cycle |
| rd_i | input | 1 | Register read strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| card_absent_i | input | 1 | High when no card is inserted |
| card_wp_i | input | 1 | High when the card is write-protected |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 3 | Active-low chip selects: card, flash, clock chip |

## Verification
The main function is tried with several byte pairs exchanged against a slave model: alternating bits, all zeros against all ones, all ones against all zeros, and edge-bit-only values. These pairs show whether the shift direction, the sampling edge or a bit position is wrong. Each select code and both clock rates are used, so a mistake in the chip-select decode or in the divider shows up as the wrong select line or the wrong busy length. The read-start sequence feeds different slave bytes to consecutive reads, which shows whether each read returns the previous byte. A trigger issued while busy must leave both the shifted byte and the length of the transfer unchanged.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  // control bit positions
  localparam int CTRL_TRIG_BIT = 6;
  localparam int CTRL_SELH_BIT = 4;
  localparam int CTRL_FAST_BIT = 2;
  localparam int CTRL_SELL_BIT = 1;

  // status bit positions
  localparam int STAT_BUSY_BIT   = 0;
  localparam int STAT_NOCARD_BIT = 3;
  localparam int STAT_WP_BIT     = 4;

  typedef struct packed {
    logic trig_rd;
    logic sel_hi;
    logic fast;
    logic sel_lo;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{trig_rd: 1'b0, sel_hi: 1'b0, fast: 1'b0, sel_lo: 1'b1};

  // select code that enables device idx (0 card, 1 flash, 2 clock chip)
  function automatic logic [1:0] dev_sel_code(input int idx);
    case (idx)
      0:       return 2'b00;
      1:       return 2'b10;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int SLOW_HALF = 100,
  parameter int FAST_HALF = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CNT_W    = $clog2(MAX_HALF + 1);
  localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_HALF - 1);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = fast_i ? FAST_LIM : SLOW_LIM;
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  a_r5_tick_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              fast_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              fast_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              busy_q, sck_q, fast_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      sck_q     <= 1'b0;
      fast_q    <= 1'b0;
      bit_cnt_q <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_q      <= '0;
    end else if (start_i && !busy_q) begin
      busy_q    <= 1'b1;
      sck_q     <= 1'b0;
      fast_q    <= fast_i;
      bit_cnt_q <= '0;
      tx_sh_q   <= tx_i;
    end else if (busy_q && tick_i) begin
      if (!sck_q) begin
        sck_q   <= 1'b1;
        rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
      end else begin
        sck_q <= 1'b0;
        if (bit_cnt_q == LAST_BIT) begin
          busy_q <= 1'b0;
          rx_q   <= rx_sh_q;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
          tx_sh_q   <= {tx_sh_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign fast_o = fast_q;
  assign sck_o  = sck_q;
  assign mosi_o = tx_sh_q[DATA_W-1];
  assign rx_o   = rx_q;

  a_r9_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  a_r9_mosi_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$stable(mosi_o)) |-> $fell(sck_q));
  a_r4_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_q) |-> $stable(rx_q));
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> ($stable(bit_cnt_q) && $stable(tx_sh_q) && $stable(fast_q)));
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode
  import spi_bm_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic [1:0]        sel_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n_o[g] = (sel_i != dev_sel_code(g));
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_CS    = 3,
  parameter int SLOW_HALF = 100,
  parameter int FAST_HALF = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              card_absent_i,
  input  logic              card_wp_i,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  ctrl_t             ctrl_q;
  logic              data_acc, ctrl_wr, start, busy, fast_run, tick;
  logic [DATA_W-1:0] tx_byte, rx_byte, ctrl_rd, stat_rd;

  assign data_acc = (reg_addr_e'(addr_i) == REG_DATA);
  assign ctrl_wr  = wr_i && (reg_addr_e'(addr_i) == REG_CTRL);
  // the engine drops a start that arrives while busy
  assign start    = data_acc && (ctrl_q.trig_rd ? rd_i : wr_i);
  assign tx_byte  = ctrl_q.trig_rd ? {DATA_W{1'b1}} : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else if (ctrl_wr) begin
      ctrl_q.trig_rd <= wdata_i[CTRL_TRIG_BIT];
      ctrl_q.sel_hi  <= wdata_i[CTRL_SELH_BIT];
      ctrl_q.fast    <= wdata_i[CTRL_FAST_BIT];
      ctrl_q.sel_lo  <= wdata_i[CTRL_SELL_BIT];
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_TRIG_BIT] = ctrl_q.trig_rd;
    ctrl_rd[CTRL_SELH_BIT] = ctrl_q.sel_hi;
    ctrl_rd[CTRL_FAST_BIT] = ctrl_q.fast;
    ctrl_rd[CTRL_SELL_BIT] = ctrl_q.sel_lo;
    stat_rd = '0;
    stat_rd[STAT_BUSY_BIT]   = busy;
    stat_rd[STAT_NOCARD_BIT] = card_absent_i;
    stat_rd[STAT_WP_BIT]     = card_wp_i;
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      REG_DATA: rdata_o = rx_byte;
      REG_CTRL: rdata_o = ctrl_rd;
      REG_STAT: rdata_o = stat_rd;
      default:  rdata_o = '0;
    endcase
  end

  spi_tick_gen #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .fast_i (fast_run),
    .tick_o (tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tx_i    (tx_byte),
    .fast_i  (ctrl_q.fast),
    .tick_i  (tick),
    .miso_i  (miso_i),
    .busy_o  (busy),
    .fast_o  (fast_run),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .rx_o    (rx_byte)
  );

  spi_cs_decode #(.NUM_CS(NUM_CS)) u_cs (
    .sel_i  ({ctrl_q.sel_hi, ctrl_q.sel_lo}),
    .cs_n_o (cs_n_o)
  );

  a_r6_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  a_r6_none_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wdata_i[CTRL_SELH_BIT] && wdata_i[CTRL_SELL_BIT]) |=> (&cs_n_o));
  a_r3_rd_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(ctrl_q.trig_rd ? rd_i : wr_i));
  a_r7_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_e'(addr_i) == REG_STAT) |-> (rdata_o[STAT_NOCARD_BIT] == card_absent_i));
endmodule

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
  localparam int SLOW_HALF = 100;
  localparam int FAST_HALF = 3;
  // {ctrl, master byte, slave byte}
  localparam logic [23:0] VECS [5] = '{24'h04A53C, 24'h1400FF, 24'h16FF00,
                                       24'h06817E, 24'h005AC3};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = 8'h00, rdata_o;
  logic card_absent_i = 1'b0, card_wp_i = 1'b0;
  logic sck_o, mosi_o, miso_i;
  logic [2:0] cs_n_o;
  logic [7:0] slv_tx = 8'h00, slv_rx = 8'h00;
  int total = 0, bad = 0;
  logic [7:0] rd_v;
  int n;

  always #10 clk_i = ~clk_i;

  spi_byte_master #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_spi_byte_master (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .card_absent_i, .card_wp_i, .sck_o, .mosi_o, .miso_i, .cs_n_o);

  assign miso_i = slv_tx[7];
  always @(posedge sck_o) slv_rx <= {slv_rx[6:0], mosi_o};
  always @(negedge sck_o) slv_tx <= {slv_tx[6:0], 1'b0};

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling clock edge
  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1; #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic wait_idle(output int cnt);
    logic [7:0] s;
    cnt = 0;
    do begin
      bus_rd(2'd2, s);
      if (s[0]) cnt++;
    end while (s[0] && cnt < 5000);
  endtask

  function automatic logic [2:0] exp_cs(input logic [7:0] c);
    case ({c[4], c[1]})
      2'b00:   return 3'b110;
      2'b10:   return 3'b101;
      2'b11:   return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog got=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    bus_rd(2'd1, rd_v); chk("R1 ctrl reset", rd_v, 8'h02);
    bus_rd(2'd0, rd_v); chk("R1 data reset", rd_v, 8'h00);
    bus_rd(2'd2, rd_v); chk("R7 status reset", rd_v, 8'h00);
    chk("R6 cs reset", cs_n_o, 3'b111);
    chk("R9 sck idle", sck_o, 0);
    bus_rd(2'd3, rd_v); chk("R1 addr3", rd_v, 8'h00);

    // vector table: write-started transfers
    for (int i = 0; i < 5; i++) begin
      bus_wr(2'd1, VECS[i][23:16]);
      slv_tx = VECS[i][7:0];
      bus_wr(2'd0, VECS[i][15:8]);
      chk("R6 cs during transfer", cs_n_o, exp_cs(VECS[i][23:16]));
      wait_idle(n);
      chk("R5 busy length", n, 16 * (VECS[i][18] ? FAST_HALF : SLOW_HALF));
      chk("R2 byte at slave", slv_rx, VECS[i][15:8]);
      bus_rd(2'd0, rd_v); chk("R4 received byte", rd_v, VECS[i][7:0]);
      chk("R9 sck idle after", sck_o, 0);
    end

    // R2: read in write-start mode starts nothing
    bus_rd(2'd0, rd_v);
    bus_rd(2'd2, rd_v); chk("R2 read no start", rd_v[0], 0);

    // R3: read-started streaming
    bus_wr(2'd1, 8'h44);
    slv_tx = 8'h96;
    bus_rd(2'd0, rd_v); chk("R3 read returns previous", rd_v, 8'hC3);
    wait_idle(n);
    chk("R3 sends ff", slv_rx, 8'hFF);
    chk("R5 read-start length", n, 16 * FAST_HALF);
    slv_tx = 8'h69;
    bus_rd(2'd0, rd_v); chk("R3 second read", rd_v, 8'h96);
    wait_idle(n);
    bus_wr(2'd0, 8'h12);
    bus_rd(2'd2, rd_v); chk("R3 write ignored busy", rd_v[0], 0);
    chk("R3 write ignored sck", sck_o, 0);
    bus_wr(2'd1, 8'h04);
    bus_rd(2'd0, rd_v); chk("R3 write ignored data", rd_v, 8'h69);

    // R8: second trigger while busy
    slv_tx = 8'h11;
    bus_wr(2'd0, 8'hC6);
    bus_wr(2'd0, 8'h3D);
    wait_idle(n);
    chk("R8 length kept", n + 1, 16 * FAST_HALF);
    chk("R8 byte kept", slv_rx, 8'hC6);
    bus_rd(2'd2, rd_v); chk("R8 no second transfer", rd_v[0], 0);
    bus_rd(2'd0, rd_v); chk("R8 rx", rd_v, 8'h11);

    // R5: speed change mid-transfer has no effect
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'h77);
    bus_wr(2'd1, 8'h04);
    wait_idle(n);
    chk("R5 speed latched", n + 1, 16 * SLOW_HALF);

    // R1 readback, R6 decode, R7 status
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, rd_v); chk("R1 ctrl readback", rd_v, 8'h56);
    chk("R6 clock chip select", cs_n_o, 3'b011);
    bus_wr(2'd1, 8'h02);
    chk("R6 none select", cs_n_o, 3'b111);
    card_absent_i = 1'b1; card_wp_i = 1'b1;
    bus_rd(2'd2, rd_v); chk("R7 status inputs", rd_v, 8'h18);
    card_absent_i = 1'b0;
    bus_rd(2'd2, rd_v); chk("R7 wp only", rd_v, 8'h10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule